// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block supervises two reference clocks that can each drive a clock loop. It samples both references and the loop's feedback clock in one fast system clock domain. A reference counts as failed when it shows no transition while several feedback edges go by. Each reference has its own fault flag. A flag stays set once raised, and only an alarm-reset event clears it.

The block drives a select output that names the reference the loop should use. That output starts on the preferred input. When the selected reference fails and the other one is healthy, the select moves to the other reference. It does not move back on its own. An alarm reset returns the select to the preferred input. A manual override holds the select on the preferred input, while fault detection keeps running.

Top module: `ref_failover_ctrl`

## Requirements
- R1: A reference that shows no transition while 3 consecutive feedback edges pass (rising and falling both count) has its fault flag set, whichever level it is stuck at.
- R2: A reference that stops toggling for a time that covers at most 2 feedback edges does not get its fault flag set.
- R3: A fault flag (faultFlag0 for refIn0, faultFlag1 for refIn1, active high) stays set after its reference recovers, until an alarm reset.
- R4: A falling edge on alarmRstN (active low) clears both flags once. A reference that is still stuck raises its flag again while alarmRstN is still low.
- R5: An alarm reset loads selOut from prefSel.
- R6: With manOverride low, if the selected reference is flagged and the other is not, selOut moves to the other reference.
- R7: After an automatic switch, selOut stays on the new reference even if the old one recovers, and it follows a changed prefSel only on an alarm reset or an override.
- R8: While both flags are set, selOut does not change unless an override or an alarm reset acts.
- R9: While manOverride is high, selOut equals prefSel whatever the flags say, and flags still set on faults.
- R10: A synchronous reset clears both flags and loads selOut from prefSel.
- R11: selOut is 0 when refIn0 is selected and 1 when refIn1 is selected. prefSel uses the same encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| fbClk | input | 1 | Feedback clock of the loop, asynchronous |
| refIn0 | input | 1 | Reference clock 0, asynchronous |
| refIn1 | input | 1 | Reference clock 1, asynchronous |
| prefSel | input | 1 | Preferred reference (0 or 1) |
| alarmRstN | input | 1 | Alarm reset, active low, edge-triggered |
| manOverride | input | 1 | High pins selection to prefSel |
| faultFlag0 | output | 1 | Sticky fault flag of refIn0 |
| faultFlag1 | output | 1 | Sticky fault flag of refIn1 |
| selOut | output | 1 | Reference currently selected |

## Verification
The assertions assume that prefSel and manOverride are synchronous to clk. They also assume that the system clock runs much faster than the feedback and reference clocks, so every transition is seen at least once after synchronization. The stimulus drives all inputs on the falling clock edge. It runs the feedback clock at one toggle per four system cycles, and it toggles a healthy reference at least every three cycles, so a healthy input always shows a transition between two feedback edges. Each input changes at most one reference's health state per phase, so the order in which faults are detected is never ambiguous.

// File: rtl/rfo_pkg.sv
package rfo_pkg;
  // events reported by the sampling datapath to the selection control
  typedef struct packed {
    logic       alarmPulse;  // one-cycle strobe on alarm-reset assertion
    logic [1:0] refStuck;    // level: reference idle for the fault edge count
  } dpEvt_t;
endpackage

// File: rtl/rfo_sync.sv
module rfo_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rfo_datapath.sv
module rfo_datapath
  import rfo_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FAULT_EDGES = 3,
  parameter int NUM_REFS    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fbClk,
  input  logic [NUM_REFS-1:0] refIn,
  input  logic                alarmRstN,
  output dpEvt_t              evt
);
  localparam int CNT_W = $clog2(FAULT_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FAULT_EDGES);

  logic fbSync, fbLast, fbEdge;
  logic alarmSync, alarmLast;

  rfo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_fbSync (
    .clk(clk), .rst(rst), .d(fbClk), .q(fbSync)
  );
  rfo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_alarmSync (
    .clk(clk), .rst(rst), .d(alarmRstN), .q(alarmSync)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fbLast    <= 1'b0;
      alarmLast <= 1'b1;
    end else begin
      fbLast    <= fbSync;
      alarmLast <= alarmSync;
    end
  end

  assign fbEdge         = fbSync ^ fbLast;
  assign evt.alarmPulse = alarmLast & ~alarmSync;

  generate
    for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
      logic             refSync, refLast, refEdge;
      logic [CNT_W-1:0] idleCnt;

      rfo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_refSync (
        .clk(clk), .rst(rst), .d(refIn[i]), .q(refSync)
      );

      assign refEdge = refSync ^ refLast;

      always_ff @(posedge clk) begin
        if (rst) begin
          refLast <= 1'b0;
          idleCnt <= '0;
        end else begin
          refLast <= refSync;
          if (refEdge)
            idleCnt <= '0;
          else if (fbEdge && idleCnt != CNT_MAX)
            idleCnt <= idleCnt + 1'b1;
        end
      end

      assign evt.refStuck[i] = (idleCnt == CNT_MAX);
    end
  endgenerate
endmodule

// File: rtl/rfo_control.sv
module rfo_control
  import rfo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dpEvt_t     evt,
  input  logic       prefSel,
  input  logic       manOverride,
  output logic [1:0] faultFlags,
  output logic       selOut
);
  logic curBad, altBad;

  assign curBad = faultFlags[selOut];
  assign altBad = faultFlags[~selOut];

  always_ff @(posedge clk) begin
    if (rst) begin
      faultFlags <= 2'b00;
      selOut     <= prefSel;
    end else begin
      if (evt.alarmPulse) faultFlags <= 2'b00;
      else                faultFlags <= faultFlags | evt.refStuck;

      if (manOverride || evt.alarmPulse) selOut <= prefSel;
      else if (curBad && !altBad)        selOut <= ~selOut;
    end
  end
endmodule

// File: rtl/ref_failover_ctrl.sv
module ref_failover_ctrl
  import rfo_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FAULT_EDGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fbClk,
  input  logic refIn0,
  input  logic refIn1,
  input  logic prefSel,
  input  logic alarmRstN,
  input  logic manOverride,
  output logic faultFlag0,
  output logic faultFlag1,
  output logic selOut
);
  dpEvt_t     evt;
  logic [1:0] flags;

  rfo_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .FAULT_EDGES(FAULT_EDGES), .NUM_REFS(2)
  ) u_dp (
    .clk(clk), .rst(rst), .fbClk(fbClk), .refIn({refIn1, refIn0}),
    .alarmRstN(alarmRstN), .evt(evt)
  );

  rfo_control u_ctl (
    .clk(clk), .rst(rst), .evt(evt), .prefSel(prefSel),
    .manOverride(manOverride), .faultFlags(flags), .selOut(selOut)
  );

  assign faultFlag0 = flags[0];
  assign faultFlag1 = flags[1];
endmodule

// File: rtl/rfo_checker.sv
module rfo_checker (
  input logic clk,
  input logic rst,
  input logic prefSel,
  input logic manOverride,
  input logic alarmPulse,
  input logic faultFlag0,
  input logic faultFlag1,
  input logic selOut
);
  AST_RST_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!faultFlag0 && !faultFlag1 && selOut == $past(prefSel))); // R10

  AST_FLAG0_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(faultFlag0) |-> $past(alarmPulse)); // R3

  AST_FLAG1_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(faultFlag1) |-> $past(alarmPulse)); // R3

  AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
    alarmPulse |=> (!faultFlag0 && !faultFlag1)); // R4

  AST_ALARM_SEL: assert property (@(posedge clk) disable iff (rst)
    alarmPulse |=> (selOut == $past(prefSel))); // R5

  AST_AUTO_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (!manOverride && !alarmPulse && (faultFlag0 != faultFlag1) &&
     (selOut ? faultFlag1 : faultFlag0)) |=> (selOut != $past(selOut))); // R6

  AST_NO_REVERT: assert property (@(posedge clk) disable iff (rst)
    !$stable(selOut) |-> $past(rst || manOverride || alarmPulse ||
                               (faultFlag0 != faultFlag1))); // R7

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(faultFlag0 && faultFlag1 && !manOverride && !alarmPulse && !rst)
      |-> $stable(selOut)); // R8

  AST_OVERRIDE_PIN: assert property (@(posedge clk) disable iff (rst)
    $past(manOverride) |-> (selOut == $past(prefSel))); // R9
endmodule

bind ref_failover_ctrl rfo_checker u_chk (
  .clk(clk), .rst(rst), .prefSel(prefSel), .manOverride(manOverride),
  .alarmPulse(evt.alarmPulse), .faultFlag0(faultFlag0),
  .faultFlag1(faultFlag1), .selOut(selOut)
);

// File: tb/tb_ref_failover_ctrl.sv
module tb_ref_failover_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fbClk = 1'b0, refIn0 = 1'b0, refIn1 = 1'b0;
  logic prefSel = 1'b1, alarmRstN = 1'b1, manOverride = 1'b0;
  logic faultFlag0, faultFlag1, selOut;

  int total = 0, bad = 0;
  logic [1:0] stuckM = 2'b00;
  int fbCnt = 0, cnt0 = 0, cnt1 = 0, hp0 = 2, hp1 = 3;
  logic [1:0] eFlags;
  logic eSel;

  always #10 clk = ~clk;

  ref_failover_ctrl dut (
    .clk(clk), .rst(rst), .fbClk(fbClk), .refIn0(refIn0), .refIn1(refIn1),
    .prefSel(prefSel), .alarmRstN(alarmRstN), .manOverride(manOverride),
    .faultFlag0(faultFlag0), .faultFlag1(faultFlag1), .selOut(selOut)
  );

  // clock sources: feedback toggles every 4 cycles, healthy refs every 2..3
  always @(negedge clk) begin
    fbCnt++;
    if (fbCnt == 4) begin fbClk <= ~fbClk; fbCnt = 0; end
    if (!stuckM[0]) begin
      cnt0++;
      if (cnt0 >= hp0) begin refIn0 <= ~refIn0; cnt0 = 0; end
    end
    if (!stuckM[1]) begin
      cnt1++;
      if (cnt1 >= hp1) begin refIn1 <= ~refIn1; cnt1 = 0; end
    end
  end

  function automatic logic ruleSel(logic s, logic [1:0] f, logic ov, logic p);
    if (ov) return p;
    if (f[s] && !f[~s]) return ~s;
    return s;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic runPhase(input logic [1:0] nStuck, input logic p, input logic ov,
                          input logic al, input string fTag, input string sTag);
    prefSel = p;
    manOverride = ov;
    stuckM = nStuck;
    repeat (40) @(negedge clk);
    eFlags = eFlags | nStuck;
    eSel = ruleSel(eSel, eFlags, ov, p);
    if (al) begin
      alarmRstN = 1'b0;
      repeat (4) @(negedge clk);
      alarmRstN = 1'b1;
      repeat (20) @(negedge clk);
      eFlags = nStuck;
      eSel = ruleSel(p, eFlags, ov, p);
    end
    check(faultFlag0, eFlags[0], {fTag, " flag0"});
    check(faultFlag1, eFlags[1], {fTag, " flag1"});
    check(selOut, eSel, {sTag, " select"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(faultFlag0, 1'b0, "R10 reset flag0");
    check(faultFlag1, 1'b0, "R10 reset flag1");
    check(selOut, 1'b1, "R10 R11 reset select from prefSel=1");
    eFlags = 2'b00; eSel = 1'b1;

    // R2: pause ref0 for 6 cycles, at most 2 feedback edges
    repeat (10) @(negedge clk);
    stuckM = 2'b01;
    repeat (6) @(negedge clk);
    stuckM = 2'b00;
    repeat (20) @(negedge clk);
    check(faultFlag0, 1'b0, "R2 short pause flag0");

    runPhase(2'b01, 1'b1, 1'b0, 1'b0, "R1 stuck ref0", "R11 unselected fault");
    runPhase(2'b00, 1'b1, 1'b0, 1'b0, "R3 recovered ref0", "R7 select");
    runPhase(2'b10, 1'b1, 1'b1, 1'b0, "R9 detect under override", "R9");
    runPhase(2'b10, 1'b0, 1'b0, 1'b0, "R3 both", "R8 both flagged");
    runPhase(2'b10, 1'b0, 1'b0, 1'b1, "R4 rearm", "R5 alarm");
    runPhase(2'b00, 1'b0, 1'b0, 1'b1, "R4 clear", "R5 alarm");
    runPhase(2'b01, 1'b0, 1'b0, 1'b0, "R1 stuck ref0", "R6 switch");
    runPhase(2'b00, 1'b0, 1'b0, 1'b0, "R3 recovered", "R7 no revert");
    runPhase(2'b00, 1'b1, 1'b0, 1'b0, "R3 recovered", "R7 prefSel change");

    for (int ph = 0; ph < 40; ph++) begin
      logic [1:0] ns;
      logic p, ov, al;
      int r;
      ns = stuckM;
      r = $urandom % 6;
      if (r < 4) ns[r % 2] = (r < 2);
      p  = 1'($urandom % 2);
      ov = (($urandom % 4) == 0);
      al = (($urandom % 4) == 0);
      hp0 = 2 + ($urandom % 2);
      hp1 = 2 + ($urandom % 2);
      runPhase(ns, p, ov, al, al ? "R4 random" : "R1 R3 random",
               ov ? "R9 random" : (al ? "R5 random" : "R6 R7 R8 random"));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule